// File: doc/BRIEF.md
# Indexed Extended Configuration Register Port

This block holds a bank of 8-bit configuration registers behind two neighbouring I/O addresses. The lower address is the index port and the upper one is the data port. A host selects a register by writing its index to the index port. It then writes or reads that register once through the data port. A host can also write the index in the low byte and the data in the high byte of a single 16-bit transfer to the index port, which updates the register in one transaction. Each register drives its own byte of a flat output vector, which feeds the logic that uses the settings.

The bank size is a parameter and may be 16, 32 or 64 registers. The index window always ends at 0xBF, so the last sixteen registers answer at 0xB0 to 0xBF whatever the bank size. An index selects a register only for one data-port access, and the host must write the index again before the next one. One input chooses the port pair. When it is low the ports sit at 0x1CE and 0x1CF. When it is high they sit at 0x3CE and 0x3CF.

Top module: `xreg_port`

## Requirements
- R1: With `alt_base` low the index port is 0x1CE, and with it high the index port is 0x3CE. The data port is always the index port address plus one. A write to any other address changes no register, and a read from any other address returns 0xFF.
- R2: An 8-bit write (`bus_wide` low) of byte I to the index port, followed by an 8-bit write of byte D to the data port, sets the register at index I to D.
- R3: A 16-bit write (`bus_wide` high) to the index port takes the index from `bus_wdata[7:0]` and the data from `bus_wdata[15:8]`. It writes the register in that same transaction and leaves no index armed, so a data-port write that follows it is dropped.
- R4: After an index write, a read strobe on the data port places the selected register on `bus_rdata` one clock after the strobe. `bus_rdata` keeps its value in every cycle that has no read.
- R5: An index serves exactly one data-port access. A second data-port write without a new index changes nothing, and a second data-port read returns 0xFF.
- R6: The window runs from 0xC0 minus `BANK_REGS` to 0xBF. The register at index LO+k drives `reg_out[8k+7:8k]`.
- R7: An index outside the window is still consumed by its access. A write to it changes no register, and a read of it returns 0xFF.
- R8: A data-port read while no index is armed returns 0xFF and changes no state.
- R9: Reset clears all registers, clears the armed flag and sets `bus_rdata` to 0x00.
- R10: When `bus_wr` and `bus_rd` are high in the same cycle, the write is performed and the read is ignored, so `bus_rdata` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_base | input | 1 | Port pair select: 0 gives 0x1CE/0x1CF, 1 gives 0x3CE/0x3CF |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wide | input | 1 | 16-bit transfer when high |
| bus_wdata | input | 16 | Write data; only the low byte is used in 8-bit transfers |
| bus_rdata | output | 8 | Registered read data |
| reg_out | output | 8*BANK_REGS | All register contents, register k in byte k |

## Verification
The hardest condition to reach is a data-port access while the index is already spent. The spent state comes about after a read, after a write, after an out-of-range access or after a combined 16-bit write, and these follow different paths through the block. The stimulus reaches each one on purpose. It follows an index write with two data writes in a row. It follows a 16-bit write with a data write and with a data read. It drives a write and a read in the same cycle while an index is armed. A behavioural model compares every register and the read data on every clock.

// File: rtl/xreg_pkg.sv
package xreg_pkg;

    localparam logic [15:0] PAIR_LOW_ADDR  = 16'h01CE;
    localparam logic [15:0] PAIR_HIGH_ADDR = 16'h03CE;
    localparam logic [7:0]  WINDOW_TOP     = 8'hBF;
    localparam int unsigned WINDOW_END     = 192;
    localparam logic [7:0]  FILL_BYTE      = 8'hFF;

    // One decoded bus cycle; at most one of the strobes is set
    typedef struct packed {
        logic       idx_load;   // 8-bit index write
        logic       wide_wr;    // combined index+data write
        logic       data_wr;    // 8-bit data-port write
        logic       data_rd;    // data-port read
        logic       rd_any;     // any read cycle (read not overridden by write)
        logic [7:0] lo;
        logic [7:0] hi;
    } bus_op_t;

    typedef struct packed {
        logic       armed;
        logic [7:0] index;
    } sel_state_t;

endpackage

// File: rtl/xreg_decode.sv
module xreg_decode
    import xreg_pkg::*;
(
    input  logic        alt_base,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic        bus_wide,
    input  logic [15:0] bus_wdata,
    output bus_op_t     op
);

    logic [15:0] idx_port;
    logic [15:0] dat_port;

    always_comb begin
        idx_port = alt_base ? PAIR_HIGH_ADDR : PAIR_LOW_ADDR;
        dat_port = idx_port + 16'd1;
        op       = '0;
        op.lo    = bus_wdata[7:0];
        op.hi    = bus_wdata[15:8];
        if (bus_wr) begin
            if (bus_addr == idx_port) begin
                if (bus_wide) begin
                    op.wide_wr = 1'b1;
                end else begin
                    op.idx_load = 1'b1;
                end
            end else if (bus_addr == dat_port && !bus_wide) begin
                op.data_wr = 1'b1;
            end
        end else if (bus_rd) begin
            op.rd_any = 1'b1;
            if (bus_addr == dat_port) begin
                op.data_rd = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xreg_sel.sv
module xreg_sel
    import xreg_pkg::*;
#(
    parameter int unsigned BANK_REGS = 32,
    localparam int unsigned IDX_W    = $clog2(BANK_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_op_t          op,
    output logic             armed,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_slot,
    output logic [7:0]       wr_data,
    output logic             rd_update,
    output logic             rd_hit,
    output logic [IDX_W-1:0] rd_slot
);

    localparam logic [7:0] WINDOW_BASE = 8'(WINDOW_END - BANK_REGS);

    sel_state_t st_d, st_q;

    function automatic logic in_window(input logic [7:0] idx);
        return (idx >= WINDOW_BASE) && (idx <= WINDOW_TOP);
    endfunction

    function automatic logic [IDX_W-1:0] to_slot(input logic [7:0] idx);
        return IDX_W'(idx - WINDOW_BASE);
    endfunction

    always_comb begin
        st_d      = st_q;
        wr_en     = 1'b0;
        wr_slot   = '0;
        wr_data   = op.lo;
        rd_update = op.rd_any;
        rd_hit    = 1'b0;
        rd_slot   = '0;
        if (op.wide_wr) begin
            st_d.index = op.lo;
            st_d.armed = 1'b0;
            wr_en      = in_window(op.lo);
            wr_slot    = to_slot(op.lo);
            wr_data    = op.hi;
        end else if (op.idx_load) begin
            st_d.index = op.lo;
            st_d.armed = 1'b1;
        end else if (op.data_wr && st_q.armed) begin
            st_d.armed = 1'b0;
            wr_en      = in_window(st_q.index);
            wr_slot    = to_slot(st_q.index);
        end else if (op.data_rd && st_q.armed) begin
            st_d.armed = 1'b0;
            rd_hit     = in_window(st_q.index);
            rd_slot    = to_slot(st_q.index);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;

endmodule

// File: rtl/xreg_bank.sv
module xreg_bank
    import xreg_pkg::*;
#(
    parameter int unsigned BANK_REGS = 32,
    localparam int unsigned IDX_W    = $clog2(BANK_REGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_slot,
    input  logic [7:0]             wr_data,
    input  logic                   rd_update,
    input  logic                   rd_hit,
    input  logic [IDX_W-1:0]       rd_slot,
    output logic [7:0]             rdata,
    output logic [8*BANK_REGS-1:0] reg_out
);

    typedef struct packed {
        logic [BANK_REGS-1:0][7:0] regs;
        logic [7:0]                rdata;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (wr_en) begin
            bk_d.regs[wr_slot] = wr_data;
        end
        if (rd_update) begin
            bk_d.rdata = rd_hit ? bk_q.regs[rd_slot] : FILL_BYTE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    for (genvar k = 0; k < BANK_REGS; k++) begin : g_out
        assign reg_out[8*k +: 8] = bk_q.regs[k];
    end

    assign rdata = bk_q.rdata;

endmodule

// File: rtl/xreg_port.sv
module xreg_port
    import xreg_pkg::*;
#(
    parameter int unsigned BANK_REGS = 32,
    localparam int unsigned IDX_W    = $clog2(BANK_REGS),
    localparam int unsigned OUT_W    = 8 * BANK_REGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alt_base,
    input  logic [15:0]      bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_wide,
    input  logic [15:0]      bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic [OUT_W-1:0] reg_out
);

    bus_op_t          op;
    logic             sel_armed;
    logic             wr_en;
    logic [IDX_W-1:0] wr_slot;
    logic [7:0]       wr_data;
    logic             rd_update;
    logic             rd_hit;
    logic [IDX_W-1:0] rd_slot;

    xreg_decode u_decode (
        .alt_base  (alt_base),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wide  (bus_wide),
        .bus_wdata (bus_wdata),
        .op        (op)
    );

    xreg_sel #(.BANK_REGS(BANK_REGS)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .armed     (sel_armed),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .wr_data   (wr_data),
        .rd_update (rd_update),
        .rd_hit    (rd_hit),
        .rd_slot   (rd_slot)
    );

    xreg_bank #(.BANK_REGS(BANK_REGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .wr_data   (wr_data),
        .rd_update (rd_update),
        .rd_hit    (rd_hit),
        .rd_slot   (rd_slot),
        .rdata     (bus_rdata),
        .reg_out   (reg_out)
    );

endmodule

// File: rtl/xreg_port_chk.sv
module xreg_port_chk #(
    parameter int unsigned BANK_REGS = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   alt_base,
    input logic [15:0]            bus_addr,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic                   bus_wide,
    input logic [15:0]            bus_wdata,
    input logic [7:0]             bus_rdata,
    input logic [8*BANK_REGS-1:0] reg_out,
    input logic                   armed
);

    localparam logic [7:0] LO_IDX = 8'(192 - BANK_REGS);

    logic [15:0] iport;
    logic [15:0] dport;
    logic        wide_out_of_window;

    assign iport = alt_base ? 16'h03CE : 16'h01CE;
    assign dport = iport + 16'd1;
    assign wide_out_of_window = (bus_wdata[7:0] < LO_IDX) || (bus_wdata[7:0] > 8'hBF);

    AST_FOREIGN_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != iport && bus_addr != dport) |=> $stable(reg_out)); // R1

    AST_INDEX_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_wide && bus_addr == iport) |=> armed); // R2

    AST_WIDE_LEAVES_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wide && bus_addr == iport) |=> !armed); // R3

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_wr) |=> $stable(bus_rdata)); // R4

    AST_DATA_WRITE_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_wide && bus_addr == dport && armed) |=> !armed); // R5

    AST_OUT_OF_WINDOW_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wide && bus_addr == iport && wide_out_of_window) |=> $stable(reg_out)); // R7

    AST_BLIND_READ_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == dport && !armed) |=> (bus_rdata == 8'hFF)); // R8

endmodule

bind xreg_port xreg_port_chk #(.BANK_REGS(BANK_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alt_base  (alt_base),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wide  (bus_wide),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .reg_out   (reg_out),
    .armed     (sel_armed)
);

// File: tb/xreg_port_bench.sv
module xreg_port_bench;

    localparam int N  = 32;
    localparam int LO = 192 - N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alt_base = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic          bus_wide = 1'b0;
    logic [15:0]   bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [8*N-1:0] reg_out;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R9";
    bit    done = 0;

    logic [7:0] m [N];
    bit         m_armed;
    int         m_idx;
    logic [7:0] m_rdata;

    always #5 clk = ~clk;

    xreg_port #(.BANK_REGS(N)) u_xreg_port (
        .clk(clk), .rst_n(rst_n), .alt_base(alt_base), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wide(bus_wide),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reg_out(reg_out)
    );

    function automatic bit hit(input int idx);
        return idx >= LO && idx <= 191;
    endfunction

    // Behavioural reference model
    always @(posedge clk) begin
        int ip;
        if (!rst_n) begin
            for (int k = 0; k < N; k++) m[k] = 8'h00;
            m_armed = 0;
            m_idx = 0;
            m_rdata = 8'h00;
        end else begin
            ip = alt_base ? 'h3CE : 'h1CE;
            if (bus_wr) begin
                if (int'(bus_addr) == ip && bus_wide) begin
                    m_idx = int'(bus_wdata[7:0]);
                    if (hit(m_idx)) m[m_idx - LO] = bus_wdata[15:8];
                    m_armed = 0;
                end else if (int'(bus_addr) == ip) begin
                    m_idx = int'(bus_wdata[7:0]);
                    m_armed = 1;
                end else if (int'(bus_addr) == ip + 1 && !bus_wide && m_armed) begin
                    if (hit(m_idx)) m[m_idx - LO] = bus_wdata[7:0];
                    m_armed = 0;
                end
            end else if (bus_rd) begin
                if (int'(bus_addr) == ip + 1 && m_armed) begin
                    m_rdata = hit(m_idx) ? m[m_idx - LO] : 8'hFF;
                    m_armed = 0;
                end else begin
                    m_rdata = 8'hFF;
                end
            end
        end
    end

    // Compare model against design on every clock
    always @(negedge clk) begin
        logic [8*N-1:0] ev;
        if (rst_n && !done) begin
            for (int k = 0; k < N; k++) ev[8*k +: 8] = m[k];
            checks++;
            if (reg_out !== ev) begin
                errors++;
                $display("FAIL %s model reg_out act=%h exp=%h", cur_req, reg_out, ev);
            end
            checks++;
            if (bus_rdata !== m_rdata) begin
                errors++;
                $display("FAIL %s model rdata act=%h exp=%h", cur_req, bus_rdata, m_rdata);
            end
        end
    end

    task automatic expect8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rg(input int idx);
        return reg_out[8*(idx - LO) +: 8];
    endfunction

    task automatic op(input logic [15:0] a, input logic [15:0] d, input bit w, input bit r, input bit wide);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r; bus_wide = wide;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_wide = 0;
    endtask

    task automatic wr8(input logic [15:0] a, input logic [7:0] d);
        op(a, {8'h00, d}, 1, 0, 0);
    endtask

    task automatic wr16(input logic [15:0] a, input logic [15:0] d);
        op(a, d, 1, 0, 1);
    endtask

    task automatic rd(input logic [15:0] a);
        op(a, 16'h0000, 0, 1, 0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        checks++;
        if (reg_out !== '0) begin errors++; $display("FAIL R9 act=%h exp=0", reg_out); end
        expect8("R9", bus_rdata, 8'h00);

        cur_req = "R2";
        wr8(16'h01CE, 8'hB3); wr8(16'h01CF, 8'h5A);
        expect8("R2", rg('hB3), 8'h5A);

        cur_req = "R5";
        wr8(16'h01CF, 8'h77);
        expect8("R5", rg('hB3), 8'h5A);

        cur_req = "R4";
        wr8(16'h01CE, 8'hB3); rd(16'h01CF);
        expect8("R4", bus_rdata, 8'h5A);
        repeat (2) @(negedge clk);
        expect8("R4", bus_rdata, 8'h5A);
        cur_req = "R5";
        rd(16'h01CF);
        expect8("R5", bus_rdata, 8'hFF);

        cur_req = "R8";
        wr8(16'h01CE, 8'hB3); rd(16'h01CF); rd(16'h01CF);
        expect8("R8", bus_rdata, 8'hFF);

        cur_req = "R3";
        wr16(16'h01CE, 16'h3CA0);
        expect8("R3", rg('hA0), 8'h3C);
        wr8(16'h01CF, 8'h11);
        expect8("R3", rg('hA0), 8'h3C);
        rd(16'h01CF);
        expect8("R3", bus_rdata, 8'hFF);

        cur_req = "R6";
        wr8(16'h01CE, 8'hBF); wr8(16'h01CF, 8'hEE);
        expect8("R6", reg_out[8*N-1 -: 8], 8'hEE);
        wr8(16'h01CE, 8'hB0); wr8(16'h01CF, 8'h21);
        expect8("R6", reg_out[8*(N-16) +: 8], 8'h21);

        cur_req = "R7";
        wr16(16'h01CE, 16'h999F);
        wr8(16'h01CE, 8'hC0); wr8(16'h01CF, 8'h44);
        wr8(16'h01CE, 8'hC0); rd(16'h01CF);
        expect8("R7", bus_rdata, 8'hFF);
        wr8(16'h01CE, 8'h10); wr8(16'h01CF, 8'h55);
        wr8(16'h01CF, 8'h56);

        cur_req = "R1";
        alt_base = 1'b1;
        wr8(16'h01CE, 8'hA5); wr8(16'h01CF, 8'h12);
        expect8("R1", rg('hA5), 8'h00);
        wr16(16'h03CE, 16'h42A5);
        expect8("R1", rg('hA5), 8'h42);
        wr8(16'h03CE, 8'hA5); rd(16'h03CF);
        expect8("R1", bus_rdata, 8'h42);
        wr8(16'h0123, 8'h99);
        rd(16'h0123);
        expect8("R1", bus_rdata, 8'hFF);

        cur_req = "R10";
        wr8(16'h03CE, 8'hA7); rd(16'h0000);
        wr8(16'h03CE, 8'hA7);
        op(16'h03CF, 16'h0066, 1, 1, 0);
        expect8("R10", rg('hA7), 8'h66);
        expect8("R10", bus_rdata, 8'hFF);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule